// File: doc/BRIEF.md
# Parallel Flash Bus Cycle Front End

This block sits on the device side of an 8-bit parallel flash with a 64K-byte address space. It takes the active-low chip-enable, output-enable and write-enable strobes, together with the address, the incoming data byte and a digital stand-in for the elevated high-voltage level on address bit 9. All of these are asynchronous to the system clock. The block brings the whole bundle into the clock domain through one shared synchronizer, so the address and data stay aligned with the strobes that qualify them. From the synchronized strobes it works out the bus mode.

During a read it passes the synchronized address to the memory array and drives the array's byte back out. When the elevated level is present, it drives a fixed identifier code instead. In every other state it releases the data bus. During a write it captures the address when the write window opens and the data byte when the window closes. It then hands one single-cycle write event to the downstream command decoder. The write window is the span in which chip-enable and write-enable are both low. Because of this, the same logic handles writes where write-enable is the controlling strobe and writes where chip-enable is.

The data bus is split into a separate input, output and output-enable. Any change on the inputs shows up at the registered outputs on the third rising clock edge after it.

Top module: `pflash_bus_front`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the output enable `dq_oe_o` is 0, `wr_valid_o` is 0 and `mode_o` is 0 (standby).
- R2: When chip-enable and output-enable are low and write-enable is high, and write-enable was already high in the cycle where both of the others became low, `dq_oe_o` is 1, `mode_o` is 1 (read) and `dq_o` equals `rd_data_i`. In this state `rd_addr_o` carries the synchronized address.
- R3: If write-enable is low in the cycle where chip-enable and output-enable both become low, no read takes place. This holds even after write-enable later rises, until chip-enable or output-enable goes high again. While the read is blocked, `mode_o` is 5 (invalid) and `dq_oe_o` is 0.
- R4: If write-enable goes low during a read, the bus is released. It stays released, with mode 5, after write-enable returns high, until chip-enable or output-enable goes high.
- R5: When output-enable or chip-enable, whichever comes first, returns high, the read ends and `dq_oe_o` goes to 0.
- R6: While chip-enable is high, `mode_o` is 0 (standby) and `dq_oe_o` is 0, whatever the level of output-enable or write-enable.
- R7: With chip-enable low and both output-enable and write-enable high, `mode_o` is 4 (output disabled) and `dq_oe_o` is 0. With chip-enable and write-enable low and output-enable high, `mode_o` is 3 (write).
- R8: During a read with `a9_hv_i` high and address bit 1 low, `mode_o` is 2 (identifier) and `dq_o` is `DEV_CODE` (default 8'h96) when address bit 0 is 1, or `MFR_CODE` (default 8'h5A) when it is 0. With address bit 1 high, the array byte is driven as in R2.
- R9: The write address is captured when the later of chip-enable and write-enable falls. Address changes after that point do not alter the reported `wr_addr_o`.
- R10: The write data is captured when the earlier of chip-enable and write-enable rises. The reported `wr_data_o` is the last byte present before that edge.
- R11: Each write window (chip-enable and write-enable both low) produces exactly one `wr_valid_o` pulse, one clock long, after the window closes. This applies whether write-enable or chip-enable controls the cycle.
- R12: A strobe change reaches `dq_oe_o` and `mode_o` on the third rising clock edge after it.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n_i | input | 1 | Chip-enable strobe, active low, asynchronous |
| oe_n_i | input | 1 | Output-enable strobe, active low, asynchronous |
| we_n_i | input | 1 | Write-enable strobe, active low, asynchronous |
| addr_i | input | 16 | Byte address from the bus |
| a9_hv_i | input | 1 | High when address bit 9 is at the elevated level |
| dq_i | input | 8 | Data byte arriving from the bus |
| rd_data_i | input | 8 | Byte returned by the memory array for `rd_addr_o` |
| rd_addr_o | output | 16 | Synchronized address presented to the array |
| dq_o | output | 8 | Byte driven onto the bus during reads |
| dq_oe_o | output | 1 | Data bus output enable |
| mode_o | output | 3 | Bus mode: 0 standby, 1 read, 2 identifier, 3 write, 4 output disabled, 5 invalid |
| wr_valid_o | output | 1 | One-cycle write event |
| wr_addr_o | output | 16 | Address captured for the write event |
| wr_data_o | output | 8 | Data captured for the write event |

## Verification
The bench targets the order in which write-enable settles against the other two strobes. A design that only checked the current strobe levels would start driving the bus when write-enable rises inside an already-low chip-enable/output-enable window, or after write-enable glitches low during a read. The bench also changes the address after the write window opens and changes the data after it closes. A design that latched on the wrong edge would then report the later address or the stale byte. Write windows controlled by chip-enable and by write-enable are both counted, so a missed or doubled event shows up. The identifier cases toggle only address bits 0 and 1, which exposes swapped codes or a missing bit-1 qualifier.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    typedef enum logic [2:0] {
        MODE_STANDBY = 3'd0,
        MODE_READ    = 3'd1,
        MODE_ID      = 3'd2,
        MODE_WRITE   = 3'd3,
        MODE_OUTDIS  = 3'd4,
        MODE_INVALID = 3'd5
    } bus_mode_e;
endpackage

// File: rtl/pfb_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous bus inputs.
module pfb_sync #(
    parameter int              W       = 8,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= RST_VAL;
                end else if (g == 0) begin
                    stage_q[g] <= async_i;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pfb_read_ctl.sv
// Read arming, bus mode decode and read data selection.
module pfb_read_ctl
    import pfb_pkg::*;
#(
    parameter int             AW       = 16,
    parameter int             DW       = 8,
    parameter logic [DW-1:0]  MFR_CODE = 8'h5A,
    parameter logic [DW-1:0]  DEV_CODE = 8'h96
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          oe_s,
    input  logic          we_s,
    input  logic          a9_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] rd_data_i,
    output logic          dq_oe_o,
    output logic [DW-1:0] dq_o,
    output bus_mode_e     mode_o
);
    typedef struct packed {
        logic      rd;
        logic      both_lo;
        bus_mode_e mode;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      id_sel;

    assign id_sel = a9_s & ~addr_s[1];

    always_comb begin
        st_d         = st_q;
        st_d.both_lo = ~ce_s & ~oe_s;
        // a read starts only if WE was high when CE/OE became low together
        st_d.rd      = st_d.both_lo & we_s & (st_q.rd | ~st_q.both_lo);
        if (ce_s) begin
            st_d.mode = MODE_STANDBY;
        end else if (st_d.rd) begin
            st_d.mode = id_sel ? MODE_ID : MODE_READ;
        end else if (oe_s) begin
            st_d.mode = we_s ? MODE_OUTDIS : MODE_WRITE;
        end else begin
            st_d.mode = MODE_INVALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rd: 1'b0, both_lo: 1'b0, mode: MODE_STANDBY};
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_oe_o = st_q.rd;
    assign mode_o  = st_q.mode;

    always_comb begin
        if (!st_q.rd) begin
            dq_o = '0;
        end else if (id_sel) begin
            dq_o = addr_s[0] ? DEV_CODE : MFR_CODE;
        end else begin
            dq_o = rd_data_i;
        end
    end
endmodule

// File: rtl/pfb_wr_cap.sv
// Write window tracking: address at window open, data and event at close.
module pfb_wr_cap #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          we_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] dq_s,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);
    typedef struct packed {
        logic          act;
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      act_now;

    assign act_now = ~ce_s & ~we_s;

    always_comb begin
        st_d       = st_q;
        st_d.act   = act_now;
        st_d.valid = st_q.act & ~act_now;
        if (act_now && !st_q.act) begin
            st_d.addr = addr_s;
        end
        if (st_q.act && !act_now) begin
            st_d.data = dq_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid_o = st_q.valid;
    assign wr_addr_o  = st_q.addr;
    assign wr_data_o  = st_q.data;
endmodule

// File: rtl/pflash_bus_front.sv
module pflash_bus_front
    import pfb_pkg::*;
#(
    parameter int             AW          = 16,
    parameter int             DW          = 8,
    parameter int             SYNC_STAGES = 2,
    parameter logic [DW-1:0]  MFR_CODE    = 8'h5A,
    parameter logic [DW-1:0]  DEV_CODE    = 8'h96
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n_i,
    input  logic          oe_n_i,
    input  logic          we_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic          a9_hv_i,
    input  logic [DW-1:0] dq_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe_o,
    output logic [2:0]    mode_o,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);
    localparam int           SW     = 4 + AW + DW;
    localparam logic [SW-1:0] SRST  = {3'b111, {(SW-3){1'b0}}};

    logic [SW-1:0] bundle_s;
    logic          ce_s, oe_s, we_s, a9_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] dq_s;
    bus_mode_e     mode;

    pfb_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SRST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ce_n_i, oe_n_i, we_n_i, a9_hv_i, addr_i, dq_i}),
        .sync_o  (bundle_s)
    );

    assign {ce_s, oe_s, we_s, a9_s, addr_s, dq_s} = bundle_s;

    pfb_read_ctl #(.AW(AW), .DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_s      (ce_s),
        .oe_s      (oe_s),
        .we_s      (we_s),
        .a9_s      (a9_s),
        .addr_s    (addr_s),
        .rd_data_i (rd_data_i),
        .dq_oe_o   (dq_oe_o),
        .dq_o      (dq_o),
        .mode_o    (mode)
    );

    pfb_wr_cap #(.AW(AW), .DW(DW)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_s       (ce_s),
        .we_s       (we_s),
        .addr_s     (addr_s),
        .dq_s       (dq_s),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o)
    );

    assign rd_addr_o = addr_s;
    assign mode_o    = mode;
endmodule

// File: rtl/pfb_chk.sv
module pfb_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_s,
    input logic          oe_s,
    input logic          we_s,
    input logic          a9_s,
    input logic [AW-1:0] rd_addr_o,
    input logic          dq_oe_o,
    input logic [2:0]    mode_o,
    input logic          wr_valid_o
);
    p_drive_needs_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> $past(!ce_s && !oe_s && we_s));

    p_we_low_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!we_s) |-> !dq_oe_o);

    p_standby_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_s) |-> (!dq_oe_o && mode_o == 3'd0));

    p_id_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2) |-> $past(a9_s && !rd_addr_o[1]));

    p_wr_after_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> ($past(ce_s || we_s) && $past(!ce_s && !we_s, 2)));

    p_wr_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);
endmodule

bind pflash_bus_front pfb_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_pflash_bus_front.sv
`timescale 1ns/1ps
module sim_pflash_bus_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, a9 = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic [7:0]  rd_data;
    logic [15:0] rd_addr;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic [2:0]  mode;
    logic        wr_valid;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int pulse_w = 0;
    logic [15:0] got_addr = '0;
    logic [7:0]  got_data = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // array model: byte = high address byte xor low address byte
    assign rd_data = rd_addr[15:8] ^ rd_addr[7:0];

    pflash_bus_front u0 (
        .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
        .addr_i(addr), .a9_hv_i(a9), .dq_i(dq_in), .rd_data_i(rd_data),
        .rd_addr_o(rd_addr), .dq_o(dq_out), .dq_oe_o(dq_oe), .mode_o(mode),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    always @(negedge clk) begin
        if (wr_valid) begin
            pulses++;
            pulse_w++;
            got_addr = wr_addr;
            got_data = wr_data;
        end else begin
            pulse_w = 0;
        end
        if (pulse_w > 1) begin
            fails++;
            $display("FAIL R11 pulse width act=%0d exp=1", pulse_w);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic check_state(input string req, input bit eoe, input int emode, input int edq);
        check(dq_oe == eoe, {req, " oe"}, dq_oe, eoe);
        check(mode == emode[2:0], {req, " mode"}, mode, emode);
        if (eoe) check(dq_out == edq[7:0], {req, " dq"}, dq_out, edq);
    endtask

    // {ce,oe,we,a9}, addr, exp_oe, exp_mode, exp_dq
    localparam logic [31:0] VEC [9] = '{
        {4'b1110, 16'h1234, 1'b0, 3'd0, 8'h00},
        {4'b1010, 16'h1234, 1'b0, 3'd0, 8'h00},
        {4'b0010, 16'h1234, 1'b1, 3'd1, 8'h26},
        {4'b0010, 16'hABCD, 1'b1, 3'd1, 8'h66},
        {4'b0011, 16'h0001, 1'b1, 3'd2, 8'h96},
        {4'b0011, 16'h0000, 1'b1, 3'd2, 8'h5A},
        {4'b0011, 16'h0002, 1'b1, 3'd1, 8'h02},
        {4'b0110, 16'h0002, 1'b0, 3'd4, 8'h00},
        {4'b1110, 16'h0002, 1'b0, 3'd0, 8'h00}
    };
    localparam string VREQ [9] = '{"R6", "R6", "R2", "R2", "R8", "R8", "R8", "R5 R7", "R5 R6"};

    initial begin
        repeat (3) @(negedge clk);
        check(dq_oe == 1'b0 && wr_valid == 1'b0 && mode == 3'd0, "R1 reset", {dq_oe, wr_valid, mode}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dq_oe == 1'b0 && wr_valid == 1'b0 && mode == 3'd0, "R1 after reset", {dq_oe, wr_valid, mode}, 0);

        for (int i = 0; i < 9; i++) begin
            {ce_n, oe_n, we_n, a9} = VEC[i][31:28];
            addr = VEC[i][27:12];
            settle();
            check_state(VREQ[i], VEC[i][11], int'(VEC[i][10:8]), int'(VEC[i][7:0]));
        end

        // R12: latency of a strobe change
        ce_n = 1'b0; oe_n = 1'b0; addr = 16'h0102;
        @(posedge clk); @(posedge clk); #1;
        check(dq_oe == 1'b0, "R12 not before third edge", dq_oe, 0);
        @(posedge clk); #1;
        check(dq_oe == 1'b1 && mode == 3'd1, "R12 at third edge", {dq_oe, mode}, 4'h9);
        ce_n = 1'b1; oe_n = 1'b1; settle();

        // R3: WE low when CE/OE both become low blocks the read
        ce_n = 1'b0; we_n = 1'b0; settle();
        check_state("R7 write mode", 1'b0, 3, 0);
        oe_n = 1'b0; settle();
        check_state("R3 blocked", 1'b0, 5, 0);
        we_n = 1'b1; settle();
        check_state("R3 still blocked", 1'b0, 5, 0);
        oe_n = 1'b1; settle();
        oe_n = 1'b0; settle();
        check_state("R3 rearmed read", 1'b1, 1, 8'h03);

        // R4: WE dips low inside a read
        we_n = 1'b0; settle();
        check_state("R4 released", 1'b0, 5, 0);
        we_n = 1'b1; settle();
        check_state("R4 stays released", 1'b0, 5, 0);
        ce_n = 1'b1; oe_n = 1'b1; settle();
        check_state("R6 back to standby", 1'b0, 0, 0);
        pulses = 0;

        // WE-controlled write: CE low first, WE falls later, WE rises first
        ce_n = 1'b0; settle();
        addr = 16'h5555; dq_in = 8'hAA; we_n = 1'b0; settle();
        addr = 16'h1111; settle();
        dq_in = 8'h3C; settle();
        we_n = 1'b1; settle();
        dq_in = 8'h77; settle();
        check(pulses == 1, "R11 one event WE-controlled", pulses, 1);
        check(got_addr == 16'h5555, "R9 address at WE fall", got_addr, 16'h5555);
        check(got_data == 8'h3C, "R10 data at WE rise", got_data, 8'h3C);
        ce_n = 1'b1; settle();

        // CE-controlled write: WE low first, CE falls later, CE rises first
        we_n = 1'b0; addr = 16'h2AAA; dq_in = 8'h55; settle();
        check_state("R6 WE ignored in standby", 1'b0, 0, 0);
        ce_n = 1'b0; settle();
        addr = 16'h0F0F; dq_in = 8'hC3; settle();
        ce_n = 1'b1; settle();
        dq_in = 8'h00; we_n = 1'b1; settle();
        check(pulses == 2, "R11 one event CE-controlled", pulses, 2);
        check(got_addr == 16'h2AAA, "R9 address at CE fall", got_addr, 16'h2AAA);
        check(got_data == 8'hC3, "R10 data at CE rise", got_data, 8'hC3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule